// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel NOR-style flash bus. It decides when a program or erase has finished inside the flash by reading the device's status byte over and over. Software or a higher-level sequencer first issues the command sequence itself. It then pulses `start` with the operation kind, the address to poll, the byte that was programmed, a detection method and a poll budget.

Every poll is made of two full read accesses to the poll address. The two reads are judged by one of three methods. The data-polling method checks whether status bit 7 carries its true value. The toggle method checks whether status bit 6 has stopped alternating between the two reads. The combined method needs both. Status bit 7 may settle before bits 0 to 6, so the block never takes a byte from the read that detected completion. It issues one more full read, called the confirm read, and keeps that byte as the final data.

The block ends in one of three outcomes: completion with a pass or fail verdict, an erase found paused (suspended), or a timeout once the poll budget is spent. The outcome holds until the next accepted start.

Top module: `flash_done_poller`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `pass`, `timeout`, `suspended` and `bus_rd` are 0, and `final_data` is all zeros.
- R2: Each read access holds `bus_rd` high for exactly `RD_CYCLES` consecutive clocks, and `bus_rdata` is taken in the last of them. `bus_addr` equals the `poll_addr` captured at the accepted start on every clock that `bus_rd` is high.
- R3: With `method` = 2'b00 (data polling), a poll completes when bit 7 of its second read equals bit 7 of `exp_data` for a program (`op_erase` = 0), or equals 1 for an erase (`op_erase` = 1).
- R4: With `method` = 2'b01 (toggle), a poll completes when bit 6 is equal in its two reads.
- R5: With `method` = 2'b10 or 2'b11 (combined), a poll completes only when the R3 condition and the R4 condition both hold in the same poll.
- R6: With `method` other than 2'b00 during an erase, a poll in which bit 6 is equal in both reads and bit 7 of the second read is 0 ends the run with `suspended` = 1 and `done` = 0. No confirm read is made.
- R7: After a completing poll, exactly one more read is made. Its byte appears on `final_data`, and `done` goes to 1. After a timeout or a suspend, `final_data` is all zeros.
- R8: On completion of a program, `pass` is 1 only if the confirm byte equals `exp_data`. On completion of an erase, `pass` is 1. `pass` is 0 whenever `done` is 0.
- R9: Once `poll_limit` polls (a limit of 0 counts as 1) have failed to complete, `timeout` goes to 1 with `done` = 0, and no further reads are made.
- R10: The outcome outputs and `final_data` hold until the next start. A start pulse is accepted only while `busy` is 0, and a start pulse while `busy` is 1 has no effect on the run.
- R11: `busy` is 1 from the clock after an accepted start until the outcome appears, and `bus_rd` is never high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock request to begin a run |
| op_erase | input | 1 | 1: erase run, 0: program run |
| method | input | 2 | 00 data polling, 01 toggle, 1x combined |
| poll_addr | input | AW | Address used for every read of the run |
| exp_data | input | DW | Byte that was programmed |
| poll_limit | input | CNT_W | Maximum number of polls before timeout |
| bus_rd | output | 1 | Read strobe to the flash |
| bus_addr | output | AW | Read address to the flash |
| bus_rdata | input | DW | Read data from the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Completion confirmed |
| pass | output | 1 | Completion verdict |
| timeout | output | 1 | Poll budget exhausted |
| suspended | output | 1 | Erase found paused |
| final_data | output | DW | Byte from the confirm read |

## Verification
The assertions assume three things. The flash holds `bus_rdata` steady through the sampling clock of an access. The run settings are meaningful only in the clock that `start` is sampled. The read engine never gets a new request while an access is still running. The bench writes a fresh status byte only when an access begins, taking it from a scripted per-access sequence. It changes the settings only around accepted starts, except for one deliberate start pulse in mid-run that must be ignored.

// File: rtl/flash_poll_pkg.sv
// Shared types and constants for the flash completion poller.
// Assumes the flash status byte keeps its poll flag in bit 7 and its
// toggle flag in bit 6, so the data width must be at least 8.
package flash_poll_pkg;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    // Detection method encodings (bit 1 set selects the combined method)
    localparam logic [1:0] MTH_DATA   = 2'b00;
    localparam logic [1:0] MTH_TOGGLE = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ1,
        ST_READ2,
        ST_COMPARE,
        ST_CONFIRM,
        ST_DONE,
        ST_FAIL
    } poll_state_t;

    typedef enum logic [1:0] {
        VD_AGAIN,
        VD_COMPLETE,
        VD_SUSPEND
    } verdict_t;

endpackage

// File: rtl/flash_rd_engine.sv
// Single read-access sequencer.
// On a one-clock request it raises the read strobe for exactly RD_CYCLES
// clocks, captures the bus data on the last of them and pulses ack with
// the captured byte. Assumes req arrives only while no access is running.
module flash_rd_engine #(
    parameter int DW        = 8,
    parameter int RD_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    output logic          bus_rd,
    input  logic [DW-1:0] bus_rdata,
    output logic          ack,
    output logic [DW-1:0] rdata_q
);
    localparam int          CW   = $clog2(RD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RD_CYCLES - 1);

    logic          active;
    logic [CW-1:0] cnt;

    // Access timing: count strobe clocks and capture data on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            ack     <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack <= 1'b0;
            if (!active && req) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (cnt == LAST) begin
                    active  <= 1'b0;
                    ack     <= 1'b1;
                    rdata_q <= bus_rdata;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign bus_rd = active;

    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cnt == LAST) |=> !bus_rd); // R2
    AST_ACK_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(bus_rd)); // R2
    AST_NO_REQ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !active); // R2

endmodule

// File: rtl/poll_judge.sv
// Combinational judgement of one poll (two consecutive reads).
// Takes the toggle bit of the first read, the poll and toggle bits of the
// second read, and the expected poll bit. Returns whether to poll again,
// to confirm completion, or to report a paused erase.
module poll_judge
    import flash_poll_pkg::*;
(
    input  logic       r1_tog,
    input  logic       r2_poll,
    input  logic       r2_tog,
    input  logic       exp_poll,
    input  logic       erase,
    input  logic [1:0] method,
    output verdict_t   verdict
);
    logic poll_true;
    logic tog_quiet;
    logic use_tog;
    logic use_poll;

    // Method flags and per-method conditions
    always_comb begin
        poll_true = erase ? r2_poll : (r2_poll == exp_poll);
        tog_quiet = (r1_tog == r2_tog);
        use_tog   = (method != MTH_DATA);
        use_poll  = (method != MTH_TOGGLE);
    end

    // Verdict with suspend detection taking priority over completion
    always_comb begin
        if (use_tog && tog_quiet && erase && !r2_poll) begin
            verdict = VD_SUSPEND;
        end else if ((!use_poll || poll_true) && (!use_tog || tog_quiet)) begin
            verdict = VD_COMPLETE;
        end else begin
            verdict = VD_AGAIN;
        end
    end

endmodule

// File: rtl/poll_budget.sv
// Poll budget counter.
// Counts polls that did not complete and flags when the next such poll
// uses up the budget. A limit of zero is treated as one.
module poll_budget #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             exhausted
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lim_eff;
    logic [CNT_W:0]   cnt_next;

    // Effective limit and the count after one more failed poll
    always_comb begin
        lim_eff   = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        cnt_next  = {1'b0, cnt} + 1'b1;
        exhausted = (cnt_next >= lim_eff);
    end

    // Failed-poll counter, cleared at each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} < lim_eff)); // R9
    AST_STEP_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !exhausted); // R9

endmodule

// File: rtl/flash_done_poller.sv
// Flash completion poller, top level.
// A start pulse latches the run settings. The poller then repeats polls of
// two reads each at the poll address and judges them by the chosen method.
// When a poll completes it makes one confirm read and reports the byte.
// Assumes the caller has already issued the program or erase command and
// that the flash drives bus_rdata steady through each access.
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int AW        = 18,
    parameter int DW        = 8,
    parameter int CNT_W     = 16,
    parameter int RD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_erase,
    input  logic [1:0]       method,
    input  logic [AW-1:0]    poll_addr,
    input  logic [DW-1:0]    exp_data,
    input  logic [CNT_W-1:0] poll_limit,
    output logic             bus_rd,
    output logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_rdata,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             timeout,
    output logic             suspended,
    output logic [DW-1:0]    final_data
);
    poll_state_t      state;
    logic             erase_q;
    logic [1:0]       method_q;
    logic [DW-1:0]    exp_q;
    logic [AW-1:0]    addr_q;
    logic [CNT_W-1:0] lim_q;
    logic             r1_tog_q;
    logic             r2_poll_q;
    logic             r2_tog_q;
    logic [DW-1:0]    fin_q;
    logic             pass_q;
    logic             susp_q;
    logic             req_q;

    logic             rd_ack;
    logic [DW-1:0]    rd_data;
    verdict_t         verdict;
    logic             exhausted;
    logic             start_ok;
    logic             budget_step;

    // Start acceptance and budget stepping
    always_comb begin
        start_ok    = start && (state == ST_IDLE || state == ST_DONE ||
                                state == ST_FAIL);
        budget_step = (state == ST_COMPARE) && (verdict == VD_AGAIN) &&
                      !exhausted;
    end

    flash_rd_engine #(
        .DW        (DW),
        .RD_CYCLES (RD_CYCLES)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ack       (rd_ack),
        .rdata_q   (rd_data)
    );

    poll_judge u_judge (
        .r1_tog   (r1_tog_q),
        .r2_poll  (r2_poll_q),
        .r2_tog   (r2_tog_q),
        .exp_poll (exp_q[POLL_BIT]),
        .erase    (erase_q),
        .method   (method_q),
        .verdict  (verdict)
    );

    poll_budget #(
        .CNT_W (CNT_W)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .step      (budget_step),
        .limit     (lim_q),
        .exhausted (exhausted)
    );

    // Run sequencer: settings capture, read ordering and outcome registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            erase_q   <= 1'b0;
            method_q  <= MTH_DATA;
            exp_q     <= '0;
            addr_q    <= '0;
            lim_q     <= '0;
            r1_tog_q  <= 1'b0;
            r2_poll_q <= 1'b0;
            r2_tog_q  <= 1'b0;
            fin_q     <= '0;
            pass_q    <= 1'b0;
            susp_q    <= 1'b0;
            req_q     <= 1'b0;
        end else begin
            req_q <= 1'b0;
            case (state)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start_ok) begin
                        erase_q  <= op_erase;
                        method_q <= method;
                        exp_q    <= exp_data;
                        addr_q   <= poll_addr;
                        lim_q    <= poll_limit;
                        fin_q    <= '0;
                        pass_q   <= 1'b0;
                        susp_q   <= 1'b0;
                        req_q    <= 1'b1;
                        state    <= ST_READ1;
                    end
                end
                ST_READ1: begin
                    if (rd_ack) begin
                        r1_tog_q <= rd_data[TOGGLE_BIT];
                        req_q    <= 1'b1;
                        state    <= ST_READ2;
                    end
                end
                ST_READ2: begin
                    if (rd_ack) begin
                        r2_poll_q <= rd_data[POLL_BIT];
                        r2_tog_q  <= rd_data[TOGGLE_BIT];
                        state     <= ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    case (verdict)
                        VD_COMPLETE: begin
                            req_q <= 1'b1;
                            state <= ST_CONFIRM;
                        end
                        VD_SUSPEND: begin
                            susp_q <= 1'b1;
                            state  <= ST_DONE;
                        end
                        default: begin
                            if (exhausted) begin
                                state <= ST_FAIL;
                            end else begin
                                req_q <= 1'b1;
                                state <= ST_READ1;
                            end
                        end
                    endcase
                end
                ST_CONFIRM: begin
                    if (rd_ack) begin
                        fin_q  <= rd_data;
                        pass_q <= erase_q ? 1'b1 : (rd_data == exp_q);
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outcome decoding from the sequencer state
    always_comb begin
        busy       = !(state == ST_IDLE || state == ST_DONE || state == ST_FAIL);
        done       = (state == ST_DONE) && !susp_q;
        suspended  = (state == ST_DONE) && susp_q;
        timeout    = (state == ST_FAIL);
        pass       = (state == ST_DONE) && pass_q;
        final_data = fin_q;
        bus_addr   = addr_q;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout, suspended})); // R9
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R8
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_rd); // R11
    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr)); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || timeout || suspended) && !start) |=>
            $stable({done, timeout, suspended, pass, final_data})); // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11
    AST_SUSP_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> erase_q); // R6

endmodule

// File: tb/sim_flash_done_poller.sv
// Self-checking bench: a scripted flash model supplies one status byte per
// read access. Bench tasks compute the expected outcome of each run.
module sim_flash_done_poller;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int CNT_W = 16;
    localparam int RD_CYCLES = 4;
    localparam int K_DONE = 0;
    localparam int K_SUSP = 1;
    localparam int K_TOUT = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             start;
    logic             op_erase;
    logic [1:0]       method;
    logic [AW-1:0]    poll_addr;
    logic [DW-1:0]    exp_data;
    logic [CNT_W-1:0] poll_limit;
    logic             bus_rd;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_rdata;
    logic             busy, done, pass, timeout, suspended;
    logic [DW-1:0]    final_data;

    flash_done_poller #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .RD_CYCLES(RD_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .method(method), .poll_addr(poll_addr), .exp_data(exp_data),
        .poll_limit(poll_limit), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .pass(pass),
        .timeout(timeout), .suspended(suspended), .final_data(final_data)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] seq [64];
    int idx = 0;
    int run_len = 0;
    int width_err = 0;
    int addr_err = 0;
    logic [AW-1:0] cur_addr = '0;

    // Flash model: a new byte for each access
    always @(posedge bus_rd) begin
        bus_rdata = seq[(idx > 63) ? 63 : idx];
        idx = idx + 1;
    end

    // Access monitor: strobe width and address
    always @(posedge clk) begin
        if (bus_rd) begin
            run_len = run_len + 1;
            if (bus_addr != cur_addr) addr_err = addr_err + 1;
        end else if (run_len != 0) begin
            if (run_len != RD_CYCLES) width_err = width_err + 1;
            run_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] at(input int k);
        return seq[(k > 63) ? 63 : k];
    endfunction

    // Script: bit 7 true from access s7, bit 6 quiet from access ts,
    // low bits garbage up to and including access s7
    task automatic gen(input logic [7:0] fin, input int s7, input int ts);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            b[7] = (k >= s7) ? fin[7] : ~fin[7];
            b[6] = (k >= ts) ? fin[6] : (fin[6] ^ k[0]);
            if (k > s7) b[5:0] = fin[5:0];
            seq[k] = b;
        end
    endtask

    // Expected outcome, computed from the requirements
    task automatic model(input logic [1:0] m, input bit er, input logic [7:0] ex,
                         input int lim, output int kind, output logic [7:0] fin,
                         output bit ps, output int nr);
        int k = 0;
        int polls = 0;
        int lime = (lim == 0) ? 1 : lim;
        kind = -1; fin = 8'h00; ps = 1'b0;
        while (kind < 0) begin
            logic [7:0] a, b;
            bit b7ok, quiet, ut, ub;
            a = at(k); b = at(k + 1); k += 2;
            b7ok = er ? b[7] : (b[7] == ex[7]);
            quiet = (a[6] == b[6]);
            ut = (m != 2'b00); ub = (m != 2'b01);
            if (ut && quiet && er && !b[7]) kind = K_SUSP;
            else if ((!ub || b7ok) && (!ut || quiet)) begin
                fin = at(k); k++;
                ps = er ? 1'b1 : (fin == ex);
                kind = K_DONE;
            end else begin
                polls++;
                if (polls >= lime) kind = K_TOUT;
            end
        end
        nr = k;
    endtask

    task automatic run_case(input logic [1:0] m, input bit er, input logic [7:0] ex,
                            input int lim, input bit poke);
        int kind, nr, cyc;
        logic [7:0] fin;
        bit ps;
        string mreq;
        mreq = (m == 2'b00) ? "R3" : ((m == 2'b01) ? "R4" : "R5");
        cur_addr = AW'($urandom);
        idx = 0;
        @(negedge clk);
        poll_addr = cur_addr; op_erase = er; method = m; exp_data = ex;
        poll_limit = CNT_W'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            exp_data = ~ex; op_erase = ~er; method = ~m; poll_addr = ~cur_addr;
            poll_limit = 16'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (busy) begin
            check(1'b0, mreq, "run never ended", 1, 0);
            return;
        end
        model(m, er, ex, lim, kind, fin, ps, nr);
        check(done == (kind == K_DONE), (kind == K_DONE) ? "R7" : mreq, "done", done, kind == K_DONE);
        check(suspended == (kind == K_SUSP), "R6", "suspended", suspended, kind == K_SUSP);
        check(timeout == (kind == K_TOUT), "R9", "timeout", timeout, kind == K_TOUT);
        check(final_data == fin, "R7", "final_data", final_data, fin);
        check(pass == ps, "R8", "pass", pass, ps);
        check(idx == nr, (kind == K_TOUT) ? "R9" : mreq, "read count", idx, nr);
    endtask

    initial begin
        int s_idx;
        logic [7:0] s_fin;
        logic s_done;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; method = 2'b00;
        poll_addr = '0; exp_data = '0; poll_limit = '0; bus_rdata = '0;
        for (int k = 0; k < 64; k++) seq[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({busy, done, pass, timeout, suspended, bus_rd} == 6'b0, "R1",
              "outputs after reset", {busy, done, pass, timeout, suspended, bus_rd}, 0);
        check(final_data == 8'h00, "R1", "final_data after reset", final_data, 0);

        // R3: program, bit 7 settles on the second read of a poll (early bit 7)
        gen(8'hA5, 1, 64); run_case(2'b00, 1'b0, 8'hA5, 10, 1'b0);
        // R3: program, several polls before bit 7 settles
        gen(8'h3C, 5, 64); run_case(2'b00, 1'b0, 8'h3C, 10, 1'b0);
        // R8: program, confirm byte differs from the expected byte
        gen(8'h5B, 3, 64); run_case(2'b00, 1'b0, 8'h5A, 10, 1'b0);
        // R4: erase by toggle, bit 6 quiet and bit 7 true
        gen(8'hFF, 4, 4); run_case(2'b01, 1'b1, 8'hFF, 10, 1'b0);
        // R6: erase by toggle, bit 6 quiet but bit 7 stays 0
        gen(8'hFF, 64, 2); run_case(2'b01, 1'b1, 8'hFF, 10, 1'b0);
        // R5: combined, toggle quiet early but bit 7 late on a program
        gen(8'h81, 7, 2); run_case(2'b10, 1'b0, 8'h81, 10, 1'b0);
        // R9: timeout after three polls
        gen(8'h12, 64, 64); run_case(2'b00, 1'b0, 8'h12, 3, 1'b0);
        // R9: limit 0 counts as one poll
        gen(8'h12, 64, 64); run_case(2'b11, 1'b0, 8'h12, 0, 1'b0);
        // R10: start during a run is ignored
        gen(8'hC3, 9, 9); run_case(2'b10, 1'b0, 8'hC3, 10, 1'b1);
        // R10: outcome holds with no further reads
        s_idx = idx; s_fin = final_data; s_done = done;
        repeat (6) @(negedge clk);
        check(idx == s_idx, "R10", "reads after outcome", idx, s_idx);
        check(final_data == s_fin && done == s_done, "R10", "outcome held",
              final_data, s_fin);

        // Random runs
        for (int n = 0; n < 40; n++) begin
            logic [7:0] f;
            bit er;
            f = 8'($urandom);
            er = 1'($urandom);
            if (er && ($urandom % 3 != 0)) f = 8'hFF;
            gen(f, int'($urandom % 14), int'($urandom % 14));
            run_case(2'($urandom), er, er ? 8'hFF : f, int'($urandom % 8), 1'b0);
        end

        // R2: access strobe width and address over all runs
        check(width_err == 0, "R2", "strobe width errors", width_err, 0);
        check(addr_err == 0, "R2", "address errors", addr_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule